// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block brings up a chip's fundamental operating modes from a slow serial stream. Once the power-good input goes high, it reads a fixed 256-bit configuration word one bit at a time. It samples the data on the rising edge of a slow mode clock, which it generates itself by dividing the master clock. Bit 0 comes first. The block decodes the low fields into the writeback data pattern, the clock multiplier, the byte order, the write protocol, the timer interrupt disable and the output drive strength. It also checks every reserved, must-be-zero and must-be-one position, and raises an error flag if any of them is wrong.

The block holds the rest of the design in reset until the last bit has been captured. The cycle after that, it raises a done flag and releases the core reset. The mode clock keeps running after the load, but the data input is then ignored. If power-good drops, the block returns to idle, clears its outputs and reasserts the core reset. The next rising power-good starts a fresh load.

The controller has four states:
- `ST_IDLE` waits for power-good.
- `ST_SHIFT` captures one bit per mode-clock rising edge.
- `ST_DECODE` is the single cycle after the last capture, in which the decoded fields are latched.
- `ST_READY` holds the result.

The transitions are:
- IDLE to SHIFT when power-good is high.
- SHIFT to DECODE on the capture of bit 255.
- DECODE to READY unconditionally.
- Any state to IDLE whenever power-good is low.

Top module: `cfg_stream_loader`

## Requirements
- R1: `mode_clk` is a square wave with a period of 2^DIV_W master clock cycles (256 by default), low for the first half. It runs from reset onward, including after loading ends.
- R2: In the idle state, power-good high starts a load. Exactly 256 bits are captured, one on each `mode_clk` rising edge, bit 0 first. Each data bit must be stable at least 3 master cycles before that edge.
- R3: `core_rst_n` stays low and `load_done` stays low until the capture of bit 255. Both go high one master cycle after the `mode_clk` rising edge that captures bit 255.
- R4: `wb_pattern` equals stream bits 4:1, `big_endian` equals bit 8, and `tmr_int_off` equals bit 11.
- R5: `clk_mult` equals the value of stream bits 7:5 plus 2, so codes 0 to 6 give 2 to 8.
- R6: `wr_proto` equals stream bits 10:9. The codes are 00 compatible, 10 pipelined writes and 11 write re-issue.
- R7: `drive_pct` decodes stream bits 14:13 as follows: 10 gives 100, 11 gives 83, 00 gives 67 and 01 gives 50.
- R8: `cfg_err` is 1 if any of these holds: bit 0 is 1, bits 4:1 exceed 8, bits 7:5 equal 7, bits 10:9 equal 01, bit 12 is 0, or any of bits 255:15 is 1. Otherwise `cfg_err` is 0.
- R9: After `load_done`, changes on `mode_din` have no effect, and every decoded output holds its value.
- R10: Power-good low returns the block to idle within one cycle. `load_done`, `core_rst_n`, `cfg_err` and all fields go to 0, and a new rise of power-good reloads.
- R11: After `rst_n` is asserted, `load_done`, `core_rst_n`, `mode_clk`, `cfg_err` and all fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good; a high level starts or permits loading |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Divided mode clock driven to the configuration source |
| core_rst_n | output | 1 | Active-low reset for the rest of the design |
| load_done | output | 1 | Configuration loaded and decoded |
| cfg_err | output | 1 | Reserved code or fixed-value violation |
| wb_pattern | output | 4 | Writeback data pattern code |
| clk_mult | output | 4 | Clock multiplier (2 to 8; 9 for the reserved code) |
| big_endian | output | 1 | 1 for big-endian, 0 for little-endian |
| wr_proto | output | 2 | Write protocol code |
| tmr_int_off | output | 1 | Timer interrupt disable |
| drive_pct | output | 7 | Output drive strength in percent |

## Verification
The hardest conditions to reach from the ports are a violation far up in the must-be-zero region, such as bit 255 or bit 15, and the exact cycle in which `load_done` rises. Both need a full 256-bit load that stays aligned to the mode clock.

The bench tracks the falling edges of `mode_clk` and presents each new bit just after one of them, which leaves half a mode period of setup before the capturing edge. It places the single stray 1 at a chosen position in the upper region. It checks `load_done` just after the final rising edge, where it must still be low, and again one master cycle later, where it must be high. A reduced divider keeps each load at 2048 cycles.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DECODE,
        ST_READY
    } ldr_state_t;

    localparam int STREAM_BITS = 256;
    localparam int LO_BITS     = 15;   // positions 0..14 carry fields
    localparam int RSV0_POS    = 0;
    localparam int WB_LSB      = 1;
    localparam int MC_LSB      = 5;
    localparam int BE_POS      = 8;
    localparam int WP_LSB      = 9;
    localparam int TMR_POS     = 11;
    localparam int ONE_POS     = 12;
    localparam int DRV_LSB     = 13;
endpackage

// File: rtl/mode_clk_div.sv
module mode_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic mode_clk,
    output logic sample
);
    localparam int HALF = 1 << (DIV_W - 1);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // capture coincides with the edge where mode_clk rises
    assign mode_clk = cnt[DIV_W-1];
    assign sample   = (cnt == DIV_W'(HALF - 1));
endmodule

// File: rtl/cfg_shift_capture.sv
module cfg_shift_capture
    import cfg_loader_pkg::*;
#(
    parameter int NBITS = STREAM_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               en,
    input  logic               din,
    output logic [LO_BITS-1:0] lo_bits,
    output logic               hi_seen,
    output logic               last
);
    localparam int IDX_W = $clog2(NBITS);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx <= '0;
        else if (clear)  idx <= '0;
        else if (en)     idx <= idx + 1'b1;
    end

    for (genvar k = 0; k < LO_BITS; k++) begin : g_lo
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          lo_bits[k] <= 1'b0;
            else if (clear)                      lo_bits[k] <= 1'b0;
            else if (en && idx == IDX_W'(k))     lo_bits[k] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   hi_seen <= 1'b0;
        else if (clear)                               hi_seen <= 1'b0;
        else if (en && idx >= IDX_W'(LO_BITS) && din) hi_seen <= 1'b1;
    end

    assign last = en && (idx == IDX_W'(NBITS - 1));
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
    import cfg_loader_pkg::*;
(
    input  logic [LO_BITS-1:0] lo_bits,
    input  logic               hi_seen,
    output logic [3:0]         wb_pattern,
    output logic [3:0]         clk_mult,
    output logic               big_endian,
    output logic [1:0]         wr_proto,
    output logic               tmr_int_off,
    output logic [6:0]         drive_pct,
    output logic               cfg_err
);
    logic [2:0] mc_code;
    logic [1:0] drv_code;

    always_comb begin
        wb_pattern  = lo_bits[WB_LSB +: 4];
        mc_code     = lo_bits[MC_LSB +: 3];
        clk_mult    = {1'b0, mc_code} + 4'd2;
        big_endian  = lo_bits[BE_POS];
        wr_proto    = lo_bits[WP_LSB +: 2];
        tmr_int_off = lo_bits[TMR_POS];
        drv_code    = lo_bits[DRV_LSB +: 2];
        unique case (drv_code)
            2'b10:   drive_pct = 7'd100;
            2'b11:   drive_pct = 7'd83;
            2'b00:   drive_pct = 7'd67;
            default: drive_pct = 7'd50;
        endcase
        cfg_err = lo_bits[RSV0_POS]
                | (wb_pattern > 4'd8)
                | (mc_code == 3'd7)
                | (wr_proto == 2'b01)
                | ~lo_bits[ONE_POS]
                | hi_seen;
    end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfg_loader_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int NBITS = STREAM_BITS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       mode_din,
    output logic       mode_clk,
    output logic       core_rst_n,
    output logic       load_done,
    output logic       cfg_err,
    output logic [3:0] wb_pattern,
    output logic [3:0] clk_mult,
    output logic       big_endian,
    output logic [1:0] wr_proto,
    output logic       tmr_int_off,
    output logic [6:0] drive_pct
);
    ldr_state_t state, state_nx;

    logic               sample;
    logic               last;
    logic               hi_seen;
    logic [LO_BITS-1:0] lo_bits;
    logic [3:0]         d_wb, d_mult;
    logic               d_be, d_tmr, d_err;
    logic [1:0]         d_wp;
    logic [6:0]         d_pct;

    mode_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_clk (mode_clk),
        .sample   (sample)
    );

    cfg_shift_capture #(.NBITS(NBITS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_IDLE),
        .en      (state == ST_SHIFT && sample && pwr_good),
        .din     (mode_din),
        .lo_bits (lo_bits),
        .hi_seen (hi_seen),
        .last    (last)
    );

    cfg_field_decode u_dec (
        .lo_bits     (lo_bits),
        .hi_seen     (hi_seen),
        .wb_pattern  (d_wb),
        .clk_mult    (d_mult),
        .big_endian  (d_be),
        .wr_proto    (d_wp),
        .tmr_int_off (d_tmr),
        .drive_pct   (d_pct),
        .cfg_err     (d_err)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (pwr_good) state_nx = ST_SHIFT;
            ST_SHIFT:  if (last)     state_nx = ST_DECODE;
            ST_DECODE:               state_nx = ST_READY;
            ST_READY:                state_nx = ST_READY;
            default:                 state_nx = ST_IDLE;
        endcase
        if (!pwr_good) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_done   <= 1'b0;
            core_rst_n  <= 1'b0;
            cfg_err     <= 1'b0;
            wb_pattern  <= '0;
            clk_mult    <= '0;
            big_endian  <= 1'b0;
            wr_proto    <= '0;
            tmr_int_off <= 1'b0;
            drive_pct   <= '0;
        end else if (!pwr_good) begin
            load_done   <= 1'b0;
            core_rst_n  <= 1'b0;
            cfg_err     <= 1'b0;
            wb_pattern  <= '0;
            clk_mult    <= '0;
            big_endian  <= 1'b0;
            wr_proto    <= '0;
            tmr_int_off <= 1'b0;
            drive_pct   <= '0;
        end else if (state == ST_DECODE) begin
            load_done   <= 1'b1;
            core_rst_n  <= 1'b1;
            cfg_err     <= d_err;
            wb_pattern  <= d_wb;
            clk_mult    <= d_mult;
            big_endian  <= d_be;
            wr_proto    <= d_wp;
            tmr_int_off <= d_tmr;
            drive_pct   <= d_pct;
        end
    end
endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk #(
    parameter int DIV_W = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic       mode_clk,
    input logic       core_rst_n,
    input logic       load_done,
    input logic       cfg_err,
    input logic [3:0] clk_mult,
    input logic [6:0] drive_pct,
    input logic [3:0] wb_pattern
);
    localparam int DIV = 1 << DIV_W;

    logic             mclk_q;
    logic             seen_rise;
    logic [DIV_W:0]   gap;
    logic             rise_now;

    assign rise_now = mode_clk && !mclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_q    <= 1'b0;
            seen_rise <= 1'b0;
            gap       <= '0;
        end else begin
            mclk_q <= mode_clk;
            if (rise_now) begin
                seen_rise <= 1'b1;
                gap       <= (DIV_W+1)'(1);
            end else if (gap != {(DIV_W+1){1'b1}}) begin
                gap <= gap + 1'b1;
            end
        end
    end

    a_r1_mode_period: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_now && seen_rise) |-> (gap == (DIV_W+1)'(DIV)));

    a_r3_done_after_capture_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> ($past(mode_clk) && !$past(mode_clk, 2)));

    a_r3_core_reset_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> !core_rst_n);

    a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && $past(load_done)) |->
            ($stable(clk_mult) && $stable(drive_pct) && $stable(cfg_err) && $stable(wb_pattern)));

    a_r10_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!load_done && !core_rst_n));

    a_r7_pct_legal: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (drive_pct == 7'd100 || drive_pct == 7'd83 ||
                       drive_pct == 7'd67  || drive_pct == 7'd50));

    a_r5_mult_range: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (clk_mult >= 4'd2 && clk_mult <= 4'd9));
endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .mode_clk   (mode_clk),
    .core_rst_n (core_rst_n),
    .load_done  (load_done),
    .cfg_err    (cfg_err),
    .clk_mult   (clk_mult),
    .drive_pct  (drive_pct),
    .wb_pattern (wb_pattern)
);

// File: tb/cfg_stream_loader_tb.sv
`timescale 1ns/1ps
module cfg_stream_loader_tb;
    localparam int TB_DIV_W = 3;
    localparam int TB_DIV   = 1 << TB_DIV_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       mode_din = 1'b0;
    logic       mode_clk, core_rst_n, load_done, cfg_err;
    logic [3:0] wb_pattern, clk_mult;
    logic       big_endian, tmr_int_off;
    logic [1:0] wr_proto;
    logic [6:0] drive_pct;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_stream_loader #(.DIV_W(TB_DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mode_din(mode_din),
        .mode_clk(mode_clk), .core_rst_n(core_rst_n), .load_done(load_done),
        .cfg_err(cfg_err), .wb_pattern(wb_pattern), .clk_mult(clk_mult),
        .big_endian(big_endian), .wr_proto(wr_proto), .tmr_int_off(tmr_int_off),
        .drive_pct(drive_pct)
    );

    typedef struct packed {
        logic [14:0] lo;    // {drv[1:0], one, tmr, wp[1:0], be, mc[2:0], wb[3:0], b0}
        logic [7:0]  hp;    // position of a stray 1 in bits 255:15, 0 = none
        logic        err;
        logic [3:0]  mult;
        logic [6:0]  pct;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{{2'b10,1'b1,1'b0,2'b00,1'b0,3'd0,4'd0,1'b0}, 8'd0,   1'b0, 4'd2, 7'd100},
        '{{2'b11,1'b1,1'b1,2'b10,1'b1,3'd6,4'd8,1'b0}, 8'd0,   1'b0, 4'd8, 7'd83},
        '{{2'b00,1'b1,1'b0,2'b11,1'b0,3'd3,4'd5,1'b0}, 8'd0,   1'b0, 4'd5, 7'd67},
        '{{2'b01,1'b1,1'b0,2'b00,1'b1,3'd1,4'd9,1'b0}, 8'd0,   1'b1, 4'd3, 7'd50},
        '{{2'b10,1'b1,1'b0,2'b11,1'b0,3'd7,4'd2,1'b0}, 8'd0,   1'b1, 4'd9, 7'd100},
        '{{2'b10,1'b1,1'b1,2'b01,1'b0,3'd0,4'd1,1'b0}, 8'd0,   1'b1, 4'd2, 7'd100},
        '{{2'b11,1'b0,1'b0,2'b10,1'b0,3'd4,4'd3,1'b0}, 8'd0,   1'b1, 4'd6, 7'd83},
        '{{2'b00,1'b1,1'b0,2'b00,1'b0,3'd2,4'd0,1'b1}, 8'd0,   1'b1, 4'd4, 7'd67},
        '{{2'b10,1'b1,1'b0,2'b00,1'b0,3'd5,4'd7,1'b0}, 8'd255, 1'b1, 4'd7, 7'd100},
        '{{2'b01,1'b1,1'b1,2'b11,1'b1,3'd0,4'd4,1'b0}, 8'd15,  1'b1, 4'd2, 7'd50}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic stream_bit(input vec_t v, input int i);
        if (i < 15) return v.lo[i];
        return (v.hp != 8'd0) && (i == int'(v.hp));
    endfunction

    // R2: bit i presented just after a mode_clk fall, captured on the next rise
    task automatic load(input vec_t v);
        @(negedge mode_clk); #1;
        mode_din = stream_bit(v, 0);
        pwr_good = 1'b1;
        for (int i = 1; i < 256; i++) begin
            @(negedge mode_clk); #1;
            mode_din = stream_bit(v, i);
            if (i == 128) begin
                chk(!load_done && !core_rst_n, "R3 mid-load held in reset",
                    {load_done, core_rst_n}, 0);
            end
        end
        @(posedge mode_clk); #1;
        chk(load_done == 1'b0, "R3 done not yet on capture edge", load_done, 0);
        @(posedge clk); #1;
        chk(load_done && core_rst_n, "R3 done one cycle after last capture",
            {load_done, core_rst_n}, 3);
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        time t0, t1;
        int  rises;
        logic [3:0] hold_mult;
        logic [6:0] hold_pct;

        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(!load_done && !core_rst_n && !mode_clk && !cfg_err, "R11 reset outputs",
            {load_done, core_rst_n, mode_clk, cfg_err}, 0);
        chk(clk_mult == 0 && drive_pct == 0 && wb_pattern == 0, "R11 reset fields",
            clk_mult, 0);
        rst_n = 1'b1;

        // R1 mode clock period
        @(posedge mode_clk); t0 = $time;
        @(posedge mode_clk); t1 = $time;
        chk((t1 - t0) == 4 * TB_DIV, "R1 mode_clk period ns", int'(t1 - t0), 4 * TB_DIV);

        // vector table: R4..R8, R10 reload
        for (int k = 0; k < NV; k++) begin
            load(VECS[k]);
            chk(cfg_err == VECS[k].err, "R8 cfg_err", cfg_err, VECS[k].err);
            chk(clk_mult == VECS[k].mult, "R5 clk_mult", clk_mult, VECS[k].mult);
            chk(drive_pct == VECS[k].pct, "R7 drive_pct", drive_pct, VECS[k].pct);
            chk(wb_pattern == VECS[k].lo[4:1], "R4 wb_pattern", wb_pattern, VECS[k].lo[4:1]);
            chk(big_endian == VECS[k].lo[8], "R4 big_endian", big_endian, VECS[k].lo[8]);
            chk(tmr_int_off == VECS[k].lo[11], "R4 tmr_int_off", tmr_int_off, VECS[k].lo[11]);
            chk(wr_proto == VECS[k].lo[10:9], "R6 wr_proto", wr_proto, VECS[k].lo[10:9]);
            pwr_good = 1'b0;
            @(posedge clk); #1;
            chk(!load_done && !core_rst_n && !cfg_err && clk_mult == 0,
                "R10 power loss clears", {load_done, core_rst_n, cfg_err}, 0);
            repeat (3) @(posedge clk);
        end

        // R9: din ignored after done, mode clock still runs (R1)
        load(VECS[1]);
        hold_mult = clk_mult;
        hold_pct  = drive_pct;
        rises = 0;
        for (int j = 0; j < 20; j++) begin
            @(negedge mode_clk); #1;
            mode_din = j[0];
            @(posedge mode_clk); rises++;
        end
        #1;
        chk(clk_mult == hold_mult && drive_pct == hold_pct && !cfg_err && load_done,
            "R9 outputs hold after done", clk_mult, hold_mult);
        chk(rises == 20, "R1 mode_clk runs after done", rises, 20);
        pwr_good = 1'b0;
        repeat (2) @(posedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule